// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator and Interrupt Flags

This block watches the running seconds, minutes and hours of a time-of-day counter and raises an alarm when all three equal the values a host has loaded into three alarm bytes. The comparison runs once per second, in the cycle after the counter's one-second update strobe. The block also collects two other event sources from the same clock subsystem: a periodic event and an update-ended event. All three events land as sticky flags in a single status byte. Each flag has its own enable bit in a control byte. One active-high interrupt request is asserted while any flag is set together with its enable.

A host reaches the registers through a simple strobe interface. A read of the status byte returns the flags and clears them in the same access. An alarm byte whose two top bits are both 1 matches any value of its field. The hour alarm is compared as a whole byte, so in 12-hour formats the PM bit (bit 7) takes part in the match. This means 2 AM and 2 PM are distinct. The time counting itself lives outside this block.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset the three alarm bytes, the control byte and the status byte all read 0x00, and `irq` is low.
- R2: An alarm byte whose bits 7:6 are both 1 (for example 0xC0) matches every value of its field.
- R3: When `sec_tick` is sampled high, the alarm bytes are compared with `cur_sec`, `cur_min` and `cur_hour` in the following cycle. If every field matches, the alarm flag (status bit 5) is set at the end of that cycle.
- R4: If `sec_tick` stays low, no comparison is made and the alarm flag does not set, even when the time fields match the alarm bytes.
- R5: The hour comparison covers all 8 bits. A non-wildcard hour alarm of 0x82 matches hour 0x82 but not 0x02.
- R6: `irq` is high exactly when some flag is set and its enable is set. The enables sit in control bits 6 (periodic), 5 (alarm) and 4 (update-ended). A flag still sets when its enable is 0.
- R7: Reading the status byte (address 4) returns {summary, periodic, alarm, update-ended, 4'b0000}, where the summary bit equals `irq`. The same read clears every flag. An immediate second read returns 0x00, and `irq` falls after the first read.
- R8: A flag that sets in the same cycle as a status read survives the clear and is reported by the next read.
- R9: A high `per_evt` sets the periodic flag (bit 6), and a high `uend_evt` sets the update-ended flag (bit 4), at the next clock edge.
- R10: The alarm bytes (addresses 0 seconds, 1 minutes, 2 hours) read back as written. The control byte (address 3) keeps only bits 6:4 and reads 0 elsewhere. Addresses 5 to 7 read 0x00.
- R11: Read data appears on `host_rdata` after the clock edge that samples `host_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_sec | input | 8 | Current seconds field from the time counter |
| cur_min | input | 8 | Current minutes field from the time counter |
| cur_hour | input | 8 | Current hours field, bit 7 = PM in 12-hour mode |
| sec_tick | input | 1 | One-cycle strobe when the time fields advance |
| per_evt | input | 1 | Periodic event strobe |
| uend_evt | input | 1 | Update-ended event strobe |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| irq | output | 1 | Active-high interrupt request |

## Verification
A corrupted alarm byte or a wrong wildcard decode shows at the ports two cycles after a `sec_tick`, as a missing or extra alarm bit on the next status read. When the alarm enable is set, it also shows on `irq`. A flag register that fails to clear shows on the back-to-back second read of the status byte. A lost enable or summary bit shows on `irq` on the cycle after the event that should have raised it. A wrong clear-versus-set priority only shows when a status read coincides with an event, so those coincidences are driven on purpose.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
    localparam int FIELD_W  = 8;
    localparam int N_FIELDS = 3;
    localparam int ADDR_W   = 3;
    localparam int N_SRC    = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ALM_SEC = 3'd0,
        SEL_ALM_MIN = 3'd1,
        SEL_ALM_HR  = 3'd2,
        SEL_CTRL    = 3'd3,
        SEL_STAT    = 3'd4
    } reg_sel_e;

    // Source index inside the flag and enable vectors
    localparam int SRC_UEND = 0;
    localparam int SRC_ALM  = 1;
    localparam int SRC_PER  = 2;

    // Bit position of the source vector in the control and status bytes
    localparam int SRC_LSB  = 4;
endpackage

// File: rtl/rtc_alm_field_cmp.sv
module rtc_alm_field_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] alarm_val,
    input  logic [W-1:0] cur_val,
    output logic         hit
);
    logic wild;

    always_comb begin
        wild = &alarm_val[W-1:W-2];
        hit  = wild | (alarm_val == cur_val);
    end
endmodule

// File: rtl/rtc_alm_flags.sv
module rtc_alm_flags
    import rtc_alm_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] set_vec,
    input  logic          clr,
    input  logic [NS-1:0] en_next,
    output logic [NS-1:0] flags,
    output logic          irq_o
);
    typedef struct packed {
        logic [NS-1:0] flg;
        logic          irq;
    } fl_state_t;

    fl_state_t fs_d, fs_q;

    always_comb begin
        fs_d     = fs_q;
        // Clear first, then OR in the new sets so they survive the read
        fs_d.flg = (clr ? '0 : fs_q.flg) | set_vec;
        fs_d.irq = |(fs_d.flg & en_next);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign flags = fs_q.flg;
    assign irq_o = fs_q.irq;

    // R7: a read with no new sets leaves nothing behind and drops the request
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_vec == '0) |=> (flags == '0 && !irq_o));

    // R8: without a clear, every set flag stays set
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));

    // R8: a set during a clear is still visible afterwards
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_alm_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] cur_sec,
    input  logic [FW-1:0] cur_min,
    input  logic [FW-1:0] cur_hour,
    input  logic          sec_tick,
    input  logic          per_evt,
    input  logic          uend_evt,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [AW-1:0] host_addr,
    input  logic [FW-1:0] host_wdata,
    output logic [FW-1:0] host_rdata,
    output logic          irq
);
    localparam int NF = N_FIELDS;
    localparam int NS = N_SRC;

    typedef struct packed {
        logic [NF-1:0][FW-1:0] alm;
        logic [NS-1:0]         en;
        logic                  tick;
        logic [FW-1:0]         rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NF-1:0][FW-1:0] cur_vec;
    logic [NF-1:0]         hits;
    logic [NS-1:0]         set_vec;
    logic [NS-1:0]         flags;
    logic                  stat_rd;
    logic                  irq_int;

    assign cur_vec[0] = cur_sec;
    assign cur_vec[1] = cur_min;
    assign cur_vec[2] = cur_hour;

    for (genvar g = 0; g < NF; g++) begin : g_cmp
        rtc_alm_field_cmp #(.W(FW)) u_cmp (
            .alarm_val (st_q.alm[g]),
            .cur_val   (cur_vec[g]),
            .hit       (hits[g])
        );
    end

    always_comb begin
        set_vec           = '0;
        set_vec[SRC_ALM]  = st_q.tick & (&hits);
        set_vec[SRC_PER]  = per_evt;
        set_vec[SRC_UEND] = uend_evt;
        stat_rd           = host_rd && (host_addr == SEL_STAT);
    end

    always_comb begin
        st_d      = st_q;
        st_d.tick = sec_tick;
        if (host_wr) begin
            case (host_addr)
                SEL_ALM_SEC: st_d.alm[0] = host_wdata;
                SEL_ALM_MIN: st_d.alm[1] = host_wdata;
                SEL_ALM_HR:  st_d.alm[2] = host_wdata;
                SEL_CTRL:    st_d.en     = host_wdata[SRC_LSB +: NS];
                default: ;
            endcase
        end
        if (host_rd) begin
            st_d.rdata = '0;
            case (host_addr)
                SEL_ALM_SEC: st_d.rdata = st_q.alm[0];
                SEL_ALM_MIN: st_d.rdata = st_q.alm[1];
                SEL_ALM_HR:  st_d.rdata = st_q.alm[2];
                SEL_CTRL:    st_d.rdata[SRC_LSB +: NS] = st_q.en;
                SEL_STAT: begin
                    st_d.rdata[SRC_LSB +: NS] = flags;
                    st_d.rdata[FW-1]          = irq_int;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rtc_alm_flags #(.NS(NS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr     (stat_rd),
        .en_next (st_d.en),
        .flags   (flags),
        .irq_o   (irq_int)
    );

    assign host_rdata = st_q.rdata;
    assign irq        = irq_int;

    // R6: the request tracks enabled flags in both directions
    p_irq_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(flags & st_q.en));

    // R4: the alarm flag only rises in the compare cycle after a tick
    p_af_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[SRC_ALM]) |-> $past(st_q.tick));

    // R2: all-wildcard alarm always matches on a compare cycle
    p_wildcard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tick && (&st_q.alm[0][FW-1:FW-2]) && (&st_q.alm[1][FW-1:FW-2])
         && (&st_q.alm[2][FW-1:FW-2])) |=> flags[SRC_ALM]);

    // R5: hours equal except for the PM bit never raise the alarm flag
    p_pm_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tick && !flags[SRC_ALM] && !(&st_q.alm[2][FW-1:FW-2])
         && (st_q.alm[2][FW-2:0] == cur_hour[FW-2:0])
         && (st_q.alm[2][FW-1] != cur_hour[FW-1])) |=> !flags[SRC_ALM]);

    // R9: periodic and update-ended strobes land in their flags
    p_events_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (per_evt || uend_evt) |=> (flags[SRC_PER] || !$past(per_evt))
                                  && (flags[SRC_UEND] || !$past(uend_evt)));
endmodule

// File: tb/tb_rtc_alarm_unit.sv
module tb_rtc_alarm_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cur_sec, cur_min, cur_hour;
    logic       sec_tick, per_evt, uend_evt;
    logic       host_wr, host_rd;
    logic [2:0] host_addr;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rtc_alarm_unit dut (
        .clk(clk), .rst_n(rst_n),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .sec_tick(sec_tick), .per_evt(per_evt), .uend_evt(uend_evt),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    function automatic bit fmatch(input logic [7:0] a, input logic [7:0] c);
        return (a[7:6] == 2'b11) || (a == c);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic tick(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hour = h; sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd2024));
        rst_n = 1'b0; cur_sec = 0; cur_min = 0; cur_hour = 0;
        sec_tick = 0; per_evt = 0; uend_evt = 0;
        host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {7'd0, irq}, 8'h00);
        for (int a = 0; a < 5; a++) begin
            rd(a[2:0], d); chk("R1 reg", d, 8'h00);
        end

        // R10 readback, R11 hold
        wr(3'd0, 8'h5A); rd(3'd0, d); chk("R10 alm sec", d, 8'h5A);
        wr(3'd2, 8'h92); rd(3'd2, d); chk("R10 alm hr", d, 8'h92);
        wr(3'd3, 8'hFF); rd(3'd3, d); chk("R10 ctrl", d, 8'h70);
        rd(3'd6, d); chk("R10 unused", d, 8'h00);
        repeat (2) @(negedge clk);
        chk("R11 hold", host_rdata, 8'h00);
        wr(3'd3, 8'h00);

        // R4 matching time but no tick
        wr(3'd0, 8'hC0); wr(3'd1, 8'hC0); wr(3'd2, 8'hC0);
        @(negedge clk); cur_sec = 8'h10;
        repeat (4) @(negedge clk);
        rd(3'd4, d); chk("R4 no tick", d, 8'h00);
        // R2 all wildcards with tick, R6 flag without enable
        tick(8'h33, 8'h44, 8'h15);
        chk("R6 irq off", {7'd0, irq}, 8'h00);
        rd(3'd4, d); chk("R2 wildcard", d, 8'h20);
        rd(3'd4, d); chk("R7 second read", d, 8'h00);

        // R5 PM bit in hour compare, R3 exact match
        wr(3'd3, 8'h20);
        wr(3'd0, 8'hC0); wr(3'd1, 8'hC0); wr(3'd2, 8'h82);
        tick(8'h00, 8'h00, 8'h02);
        chk("R5 irq", {7'd0, irq}, 8'h00);
        rd(3'd4, d); chk("R5 am vs pm", d, 8'h00);
        tick(8'h00, 8'h00, 8'h82);
        chk("R3 irq", {7'd0, irq}, 8'h01);
        rd(3'd4, d); chk("R3 pm match", d, 8'hA0);
        chk("R7 irq fell", {7'd0, irq}, 8'h00);

        // R9 events with and without enables
        wr(3'd3, 8'h10);
        @(negedge clk); per_evt = 1'b1;
        @(negedge clk); per_evt = 1'b0;
        chk("R9 per no en irq", {7'd0, irq}, 8'h00);
        @(negedge clk); uend_evt = 1'b1;
        @(negedge clk); uend_evt = 1'b0;
        chk("R9 uend irq", {7'd0, irq}, 8'h01);
        rd(3'd4, d); chk("R9 flags", d, 8'hD0);

        // R8 set during status read
        wr(3'd3, 8'h40);
        @(negedge clk); host_rd = 1'b1; host_addr = 3'd4; per_evt = 1'b1;
        @(negedge clk); host_rd = 1'b0; per_evt = 1'b0;
        chk("R8 old data", host_rdata, 8'h00);
        chk("R8 irq kept", {7'd0, irq}, 8'h01);
        rd(3'd4, d); chk("R8 survives", d, 8'hC0);

        // Random alarms and times
        for (int it = 0; it < 60; it++) begin
            logic [7:0] al [3];
            logic [7:0] tv [3];
            logic aie, hit;
            for (int f = 0; f < 3; f++) begin
                al[f] = ($urandom % 4 == 0) ? (8'hC0 | 8'($urandom % 64)) : 8'($urandom % 8);
                tv[f] = ($urandom % 2 == 0) ? al[f] : 8'($urandom % 8);
                if (tv[f][7:6] == 2'b11) tv[f] = 8'($urandom % 8);
            end
            if ($urandom % 4 == 0) tv[2] = al[2] ^ 8'h80;
            aie = 1'($urandom);
            hit = fmatch(al[0], tv[0]) && fmatch(al[1], tv[1]) && fmatch(al[2], tv[2]);
            wr(3'd0, al[0]); wr(3'd1, al[1]); wr(3'd2, al[2]);
            wr(3'd3, {2'b00, aie, 5'b0});
            tick(tv[0], tv[1], tv[2]);
            chk("R6 rand irq", {7'd0, irq}, {7'd0, hit && aie});
            rd(3'd4, d); chk("R3 rand stat", d, {hit && aie, 1'b0, hit, 5'b0});
            rd(3'd4, d); chk("R7 rand clear", d, 8'h00);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule